// File: doc/BRIEF.md
# Credit-Gated Ingress Path Steering

This block sits between a network receive port and a host DMA engine and decides, for each arriving packet descriptor, whether the packet may be written straight into host memory or must first be parked in a local overflow queue. A shared pool of credits bounds the amount of receive data in flight towards the host. The pool is sized to the cache capacity set aside for I/O. A packet that finds a credit takes it and goes out on the fast DMA request stream. A packet that finds the pool empty is enqueued on the slow path. The host returns one credit per strobe once it has consumed a packet.

A flow that once falls back to the slow path is demoted. All of its later packets also go to the slow path until its parked backlog has been drained to the host. Drain requests cost credits just like fast requests. When the backlog reaches zero the flow returns to the fast path. Because of this, no packet of a flow can overtake an earlier one across the two paths. When the overflow queue reports full, a packet bound for it is discarded and counted against its flow.

Top module: `ingress_steer`

## Requirements
- R1: After reset the credit level equals the CREDITS parameter, every flow is in the normal state with an empty backlog, and no fast, slow, drain or drop output is asserted.
- R2: A descriptor of a normal flow accepted while the credit level is non-zero appears on the fast request outputs (flow and tag) one cycle later, and the credit level drops by one.
- R3: A descriptor of a normal flow that arrives with a zero credit level and the overflow queue not full appears on the slow enqueue outputs one cycle later, and the flow becomes demoted. At most one of fast, slow and drop is asserted in any cycle.
- R4: While a flow is demoted or draining, every new descriptor of that flow goes to the slow path (or is dropped when the queue is full), even when credits are free.
- R5: A drain request names a flow with a non-empty backlog and consumes one credit. It is only issued when a credit is left after any fast request accepted in the same cycle, so a fast arrival wins the last credit.
- R6: When a flow's last parked packet is drained, the flow returns to the normal state and its next descriptor takes the fast path if a credit is free.
- R7: A credit return and a single credit consumption in the same cycle leave the level unchanged. The level never exceeds CREDITS, never goes below zero, and returns to CREDITS once every issued credit has been given back.
- R8: A descriptor bound for the slow path while slow_full is high is dropped: drop_valid and drop_flow are asserted one cycle later, and the flow's drop counter, read through drop_sel/drop_cnt, increments by one. A drop does not change the flow's state.
- R9: For every flow, the sequence of tags reaching the host (fast requests, plus drained packets taken from the head of that flow's overflow queue) equals the arrival sequence with dropped packets removed.
- R10: Drain requests rotate among the flows that have a backlog, starting the search from the flow after the last one granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | An arriving descriptor is present this cycle |
| pkt_flow | input | FLOW_W | Flow index of the descriptor |
| pkt_tag | input | TAG_W | Descriptor tag, carried through unchanged |
| slow_full | input | 1 | Overflow queue cannot accept another packet |
| credit_ret | input | 1 | Host gives back one credit |
| drop_sel | input | FLOW_W | Flow whose drop counter is shown on drop_cnt |
| fast_valid | output | 1 | Fast-path DMA request |
| fast_flow | output | FLOW_W | Flow of the fast request |
| fast_tag | output | TAG_W | Tag of the fast request |
| slow_valid | output | 1 | Enqueue into the overflow queue |
| slow_flow | output | FLOW_W | Flow of the enqueued packet |
| slow_tag | output | TAG_W | Tag of the enqueued packet |
| drain_valid | output | 1 | Move the head packet of a flow's overflow queue to the host |
| drain_flow | output | FLOW_W | Flow to drain |
| drop_valid | output | 1 | A descriptor was discarded |
| drop_flow | output | FLOW_W | Flow of the discarded descriptor |
| drop_cnt | output | DROP_W | Saturating drop count of flow drop_sel |
| credit_level | output | LVL_W | Credits currently in the pool |

## Verification
The pool-bound assertions rely on the host never returning more credits than it has received through fast and drain requests. The backlog assertions rely on the overflow queue raising slow_full before any one flow could hold 2^BACKLOG_W - 1 packets. The bench keeps to both. Its host model counts the credits it holds and returns one only while that count is positive. Its queue model raises slow_full once its total occupancy reaches a capacity of six, well below the backlog counter limit. Random traffic over four flows with only four credits keeps flows passing through demotion, drain and resume, while directed cycles pin the credit tie-break, the cancelling return and the drop corner.

// File: rtl/steer_pkg.sv
// Package: shared types for the ingress steering block.
// Assumes nothing beyond being compiled before its users.
package steer_pkg;

    // Per-flow steering mode
    typedef enum logic [1:0] {
        FL_NORMAL   = 2'd0,   // packets may take the fast path
        FL_DEMOTED  = 2'd1,   // backlog parked, no drain issued yet
        FL_DRAINING = 2'd2    // backlog being moved to the host
    } flow_mode_e;

endpackage

// File: rtl/credit_pool.sv
// Module: credit_pool
// Holds the shared credit count. Each cycle it adds one for a host
// return and removes zero, one or two for the requests granted.
// Assumes: the host never returns more credits than were handed out, and
// the caller never takes more than the level shows.
module credit_pool #(
    parameter int CREDITS = 32,
    parameter int LVL_W   = $clog2(CREDITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret,
    input  logic [1:0]       take,
    output logic [LVL_W-1:0] level
);

    logic [LVL_W-1:0] level_q;

    // Update the pool with this cycle's return and consumption
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LVL_W'(CREDITS);
        end else begin
            level_q <= level_q + LVL_W'(ret) - LVL_W'(take);
        end
    end

    assign level = level_q;

    AST_POOL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(CREDITS)); // R7
    AST_NO_UNDERDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        LVL_W'(take) <= level_q); // R7
    AST_RET_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && take == 2'd1) |=> (level_q == $past(level_q))); // R7

endmodule

// File: rtl/flow_table.sv
// Module: flow_table
// Per-flow record of steering mode, parked-packet backlog and drop count.
// One arrival update and one drain update may land in the same cycle,
// on the same flow or on different flows.
// Assumes: a drain is only requested for a flow with a non-zero backlog,
// and the overflow queue fills before any backlog counter would wrap.
module flow_table
    import steer_pkg::*;
#(
    parameter int FLOWS     = 16,
    parameter int FLOW_W    = $clog2(FLOWS),
    parameter int BACKLOG_W = 8,
    parameter int DROP_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arr_slow,
    input  logic                 arr_drop,
    input  logic [FLOW_W-1:0]    arr_flow,
    input  logic                 drn_go,
    input  logic [FLOW_W-1:0]    drn_flow,
    input  logic [FLOW_W-1:0]    drop_sel,
    output flow_mode_e           mode    [FLOWS],
    output logic [BACKLOG_W-1:0] backlog [FLOWS],
    output logic [DROP_W-1:0]    drop_cnt
);

    flow_mode_e           mode_q    [FLOWS];
    logic [BACKLOG_W-1:0] backlog_q [FLOWS];
    logic [DROP_W-1:0]    drops_q   [FLOWS];

    for (genvar i = 0; i < FLOWS; i++) begin : g_flow
        logic                 inc;
        logic                 dec;
        logic                 hit_drop;
        logic [BACKLOG_W-1:0] backlog_n;

        // Decode which updates address this entry
        always_comb begin
            inc       = arr_slow && (arr_flow == FLOW_W'(i));
            dec       = drn_go   && (drn_flow == FLOW_W'(i));
            hit_drop  = arr_drop && (arr_flow == FLOW_W'(i));
            backlog_n = backlog_q[i] + BACKLOG_W'(inc) - BACKLOG_W'(dec);
        end

        // Advance mode and backlog of this flow
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[i]    <= FL_NORMAL;
                backlog_q[i] <= '0;
            end else begin
                backlog_q[i] <= backlog_n;
                if (dec) begin
                    mode_q[i] <= (backlog_n == '0) ? FL_NORMAL : FL_DRAINING;
                end else if (inc && mode_q[i] == FL_NORMAL) begin
                    mode_q[i] <= FL_DEMOTED;
                end
            end
        end

        // Count discarded descriptors, holding at the top value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                drops_q[i] <= '0;
            end else if (hit_drop && drops_q[i] != '1) begin
                drops_q[i] <= drops_q[i] + DROP_W'(1);
            end
        end

        assign mode[i]    = mode_q[i];
        assign backlog[i] = backlog_q[i];

        AST_BACKLOG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] != FL_NORMAL) |-> (backlog_q[i] != '0)); // R6
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !dec) |-> (backlog_q[i] != '1)); // R4
        AST_DRAIN_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            dec |-> (backlog_q[i] != '0)); // R5
        AST_NORMAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] == FL_NORMAL) |-> (backlog_q[i] == '0)); // R6
    end

    assign drop_cnt = drops_q[drop_sel];

endmodule

// File: rtl/drain_arb.sv
// Module: drain_arb
// Round-robin picker over flows that have a parked backlog. The search
// starts at the flow after the last grant; the pointer moves only when a
// grant is actually issued.
// Assumes: FLOWS is a power of two so the index wraps naturally.
module drain_arb #(
    parameter int FLOWS  = 16,
    parameter int FLOW_W = $clog2(FLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLOWS-1:0]  eligible,
    input  logic              allow,
    output logic              grant,
    output logic [FLOW_W-1:0] grant_flow
);

    logic [FLOW_W-1:0] ptr_q;
    logic [FLOW_W-1:0] cand;
    logic [FLOW_W-1:0] pick;
    logic              found;

    // Find the first eligible flow at or after the pointer
    always_comb begin
        cand  = '0;
        pick  = '0;
        found = 1'b0;
        for (int off = 0; off < FLOWS; off++) begin
            cand = ptr_q + FLOW_W'(off);
            if (!found && eligible[cand]) begin
                pick  = cand;
                found = 1'b1;
            end
        end
    end

    assign grant      = allow && found;
    assign grant_flow = pick;

    // Move the pointer past the flow just served
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (grant) begin
            ptr_q <= pick + FLOW_W'(1);
        end
    end

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> eligible[grant_flow]); // R10
    AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (eligible == '0) |-> !grant); // R5

endmodule

// File: rtl/ingress_steer.sv
// Module: ingress_steer (top)
// Steers each arriving descriptor to the fast DMA path, the overflow
// queue, or the drop outcome. It also issues drain requests for demoted
// flows. The decisions use the registered credit level and flow table.
// All outputs are registered and appear one cycle after the decision.
// Assumes: the overflow queue holds per-flow FIFO order and moves the head
// packet of drain_flow to the host for each drain request; the DMA engine
// takes a request every cycle; FLOWS is a power of two.
module ingress_steer
    import steer_pkg::*;
#(
    parameter int FLOWS     = 16,
    parameter int CREDITS   = 32,
    parameter int TAG_W     = 8,
    parameter int BACKLOG_W = 8,
    parameter int DROP_W    = 8,
    localparam int FLOW_W   = $clog2(FLOWS),
    localparam int LVL_W    = $clog2(CREDITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [FLOW_W-1:0] pkt_flow,
    input  logic [TAG_W-1:0]  pkt_tag,
    input  logic              slow_full,
    input  logic              credit_ret,
    input  logic [FLOW_W-1:0] drop_sel,
    output logic              fast_valid,
    output logic [FLOW_W-1:0] fast_flow,
    output logic [TAG_W-1:0]  fast_tag,
    output logic              slow_valid,
    output logic [FLOW_W-1:0] slow_flow,
    output logic [TAG_W-1:0]  slow_tag,
    output logic              drain_valid,
    output logic [FLOW_W-1:0] drain_flow,
    output logic              drop_valid,
    output logic [FLOW_W-1:0] drop_flow,
    output logic [DROP_W-1:0] drop_cnt,
    output logic [LVL_W-1:0]  credit_level
);

    flow_mode_e           mode    [FLOWS];
    logic [BACKLOG_W-1:0] backlog [FLOWS];
    logic [FLOWS-1:0]     eligible;
    logic [LVL_W-1:0]     level;
    flow_mode_e           mode_cur;
    logic                 have_one;
    logic                 have_two;
    logic                 arr_fast;
    logic                 arr_slow;
    logic                 arr_drop;
    logic                 drn_allow;
    logic                 drn_go;
    logic [FLOW_W-1:0]    drn_flow;
    logic [1:0]           take;

    // Steering decision for the arriving descriptor
    always_comb begin
        mode_cur = mode[pkt_flow];
        have_one = (level != '0);
        have_two = (level > LVL_W'(1));
        arr_fast = pkt_valid && (mode_cur == FL_NORMAL) && have_one;
        arr_slow = pkt_valid && !arr_fast && !slow_full;
        arr_drop = pkt_valid && !arr_fast && slow_full;
    end

    // A drain needs a credit left over after the fast arrival
    always_comb begin
        drn_allow = arr_fast ? have_two : have_one;
        take      = {1'b0, arr_fast} + {1'b0, drn_go};
    end

    // Flows with parked packets may be drained
    for (genvar i = 0; i < FLOWS; i++) begin : g_elig
        assign eligible[i] = (mode[i] != FL_NORMAL) && (backlog[i] != '0);
    end

    credit_pool #(
        .CREDITS (CREDITS),
        .LVL_W   (LVL_W)
    ) u_pool (
        .clk   (clk),
        .rst_n (rst_n),
        .ret   (credit_ret),
        .take  (take),
        .level (level)
    );

    flow_table #(
        .FLOWS     (FLOWS),
        .FLOW_W    (FLOW_W),
        .BACKLOG_W (BACKLOG_W),
        .DROP_W    (DROP_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_slow (arr_slow),
        .arr_drop (arr_drop),
        .arr_flow (pkt_flow),
        .drn_go   (drn_go),
        .drn_flow (drn_flow),
        .drop_sel (drop_sel),
        .mode     (mode),
        .backlog  (backlog),
        .drop_cnt (drop_cnt)
    );

    drain_arb #(
        .FLOWS  (FLOWS),
        .FLOW_W (FLOW_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (eligible),
        .allow      (drn_allow),
        .grant      (drn_go),
        .grant_flow (drn_flow)
    );

    // Register the request outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_valid  <= 1'b0;
            slow_valid  <= 1'b0;
            drain_valid <= 1'b0;
            drop_valid  <= 1'b0;
            fast_flow   <= '0;
            fast_tag    <= '0;
            slow_flow   <= '0;
            slow_tag    <= '0;
            drain_flow  <= '0;
            drop_flow   <= '0;
        end else begin
            fast_valid  <= arr_fast;
            slow_valid  <= arr_slow;
            drain_valid <= drn_go;
            drop_valid  <= arr_drop;
            fast_flow   <= pkt_flow;
            fast_tag    <= pkt_tag;
            slow_flow   <= pkt_flow;
            slow_tag    <= pkt_tag;
            drain_flow  <= drn_flow;
            drop_flow   <= pkt_flow;
        end
    end

    assign credit_level = level;

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fast_valid, slow_valid, drop_valid})); // R3
    AST_DEMOTED_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && mode[pkt_flow] != FL_NORMAL) |=> !fast_valid); // R4
    AST_DRAIN_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> ($past(level) != '0)); // R5
    AST_FAST_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        fast_valid |-> ($past(level) != '0)); // R2
    AST_TIE_FAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_fast && level == LVL_W'(1)) |=> !drain_valid); // R5

endmodule

// File: tb/ingress_steer_test.sv
// Bench for ingress_steer: directed corner cases followed by seeded random
// traffic. A host model returns credits, and a queue model emulates the
// overflow buffer. A scoreboard checks per-flow order at the host.
module ingress_steer_test;

    localparam int FLOWS   = 4;
    localparam int CREDITS = 4;
    localparam int TAG_W   = 8;
    localparam int FW      = 2;
    localparam int LW      = 3;
    localparam int BUF_CAP = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pkt_valid;
    logic [FW-1:0] pkt_flow;
    logic [TAG_W-1:0] pkt_tag;
    logic          slow_full;
    logic          credit_ret;
    logic [FW-1:0] drop_sel;
    logic          fast_valid, slow_valid, drain_valid, drop_valid;
    logic [FW-1:0] fast_flow, slow_flow, drain_flow, drop_flow;
    logic [TAG_W-1:0] fast_tag, slow_tag;
    logic [3:0]    drop_cnt;
    logic [LW-1:0] credit_level;

    int n_tests = 0;
    int n_fail  = 0;
    int held    = 0;
    int occ     = 0;
    bit done    = 1'b0;
    int exp_q [FLOWS][$];
    int buf_q [FLOWS][$];
    int next_tag = 0;

    always #10 clk = ~clk;

    ingress_steer #(
        .FLOWS(FLOWS), .CREDITS(CREDITS), .TAG_W(TAG_W),
        .BACKLOG_W(4), .DROP_W(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_flow(pkt_flow),
        .pkt_tag(pkt_tag), .slow_full(slow_full), .credit_ret(credit_ret),
        .drop_sel(drop_sel), .fast_valid(fast_valid), .fast_flow(fast_flow),
        .fast_tag(fast_tag), .slow_valid(slow_valid), .slow_flow(slow_flow),
        .slow_tag(slow_tag), .drain_valid(drain_valid), .drain_flow(drain_flow),
        .drop_valid(drop_valid), .drop_flow(drop_flow), .drop_cnt(drop_cnt),
        .credit_level(credit_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard update from the outputs of the edge just passed
    task automatic monitor();
        int h;
        if (fast_valid) begin
            h = (exp_q[fast_flow].size() > 0) ? exp_q[fast_flow].pop_front() : -1;
            check(h == int'(fast_tag), "R9 fast order", int'(fast_tag), h);
            held++;
        end
        if (drain_valid) begin
            int b;
            b = (buf_q[drain_flow].size() > 0) ? buf_q[drain_flow].pop_front() : -2;
            if (b >= 0) occ--;
            h = (exp_q[drain_flow].size() > 0) ? exp_q[drain_flow].pop_front() : -1;
            check(b == h, "R9 drain order", b, h);
            held++;
        end
        if (slow_valid) begin
            buf_q[slow_flow].push_back(int'(slow_tag));
            occ++;
        end
        if (drop_valid) begin
            check(exp_q[drop_flow].size() > 0, "R8 drop flow", 0, 1);
            if (exp_q[drop_flow].size() > 0) void'(exp_q[drop_flow].pop_back());
        end
        check(int'(credit_level) + held == CREDITS, "R7 credit balance",
              int'(credit_level) + held, CREDITS);
    endtask

    // Drive one cycle of stimulus and observe its registered result
    task automatic cyc(input bit v, input int f, input bit ret, input bit full);
        pkt_valid  = v;
        pkt_flow   = FW'(f);
        pkt_tag    = TAG_W'(next_tag);
        credit_ret = ret && (held > 0);
        slow_full  = full;
        if (credit_ret) held--;
        if (v) begin
            exp_q[f].push_back(next_tag % 256);
            next_tag = (next_tag + 1) % 256;
        end
        @(negedge clk);
        monitor();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst_n = 1'b0; pkt_valid = 1'b0; pkt_flow = '0; pkt_tag = '0;
        slow_full = 1'b0; credit_ret = 1'b0; drop_sel = 2'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(credit_level == LW'(CREDITS), "R1 reset level", int'(credit_level), CREDITS);
        check(!fast_valid && !slow_valid && !drain_valid && !drop_valid,
              "R1 reset outputs", int'({fast_valid, slow_valid, drain_valid, drop_valid}), 0);

        // R2: fast path takes a credit
        next_tag = 1;
        cyc(1, 0, 0, 0);
        check(fast_valid && fast_flow == 0 && fast_tag == 1, "R2 fast issue", int'(fast_valid), 1);
        check(credit_level == 3, "R2 level", int'(credit_level), 3);
        cyc(1, 1, 0, 0); cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
        check(credit_level == 0, "R2 pool empty", int'(credit_level), 0);

        // R3: no credit demotes flow 0
        cyc(1, 0, 0, 0);
        check(slow_valid && !fast_valid && slow_flow == 0, "R3 slow enqueue", int'(slow_valid), 1);
        // R4: return arrives, pool was empty at decision
        cyc(1, 0, 1, 0);
        check(slow_valid && !drain_valid, "R4 still slow", int'(slow_valid), 1);
        check(credit_level == 1, "R7 return", int'(credit_level), 1);
        // R4/R5: credit free but flow demoted, drain uses it
        cyc(1, 0, 0, 0);
        check(slow_valid && !fast_valid, "R4 slow with credit", int'(fast_valid), 0);
        check(drain_valid && drain_flow == 0, "R5 drain issue", int'(drain_valid), 1);
        check(credit_level == 0, "R5 drain consumes", int'(credit_level), 0);
        cyc(0, 0, 1, 0);
        // R5/R7: fast wins the last credit, return cancels consume
        cyc(1, 2, 1, 0);
        check(fast_valid && fast_flow == 2, "R5 fast wins tie", int'(fast_valid), 1);
        check(!drain_valid, "R5 no drain on tie", int'(drain_valid), 0);
        check(credit_level == 1, "R7 return cancels consume", int'(credit_level), 1);
        cyc(0, 0, 0, 0);
        check(drain_valid && drain_flow == 0, "R5 second drain", int'(drain_valid), 1);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        check(drain_valid && credit_level == 0, "R6 last drain", int'(drain_valid), 1);
        cyc(0, 0, 1, 0);
        // R6: flow resumes fast path
        cyc(1, 0, 0, 0);
        check(fast_valid && fast_flow == 0, "R6 resume fast", int'(fast_valid), 1);
        // R8: drop when queue full
        cyc(1, 3, 0, 1);
        check(drop_valid && drop_flow == 3 && !slow_valid, "R8 drop", int'(drop_valid), 1);
        check(drop_cnt == 1, "R8 drop count", int'(drop_cnt), 1);
        cyc(0, 0, 1, 0);
        cyc(1, 3, 0, 0);
        check(fast_valid && fast_flow == 3, "R8 drop keeps normal", int'(fast_valid), 1);
        while (held > 0) cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        check(credit_level == LW'(CREDITS), "R7 refill", int'(credit_level), CREDITS);

        // R10: two demoted flows drained alternately
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        cyc(1, 1, 0, 0); cyc(1, 2, 0, 0); cyc(1, 1, 0, 0); cyc(1, 2, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        check(drain_valid && drain_flow == 1, "R10 first grant", int'(drain_flow), 1);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        check(drain_valid && drain_flow == 2, "R10 rotate", int'(drain_flow), 2);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        check(drain_valid && drain_flow == 1, "R10 wrap", int'(drain_flow), 1);

        // Random traffic, R9 order and R7 balance checked every cycle
        drop_sel = 2'd0;
        for (int k = 0; k < 4000; k++) begin
            cyc(($urandom % 100) < 55, int'($urandom % FLOWS),
                ($urandom % 100) < 40, occ >= BUF_CAP);
        end
        for (int k = 0; k < 3000; k++) begin
            int left;
            left = held + occ;
            for (int f = 0; f < FLOWS; f++) left += exp_q[f].size();
            if (left == 0) break;
            cyc(0, 0, 1, 0);
        end
        for (int f = 0; f < FLOWS; f++) begin
            check(exp_q[f].size() == 0, "R9 all delivered", exp_q[f].size(), 0);
        end
        check(credit_level == LW'(CREDITS), "R7 final level", int'(credit_level), CREDITS);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule